// File: doc/BRIEF.md
# Edge-Triggered Half-Bridge Deadtime Controller

This block drives the two gate enables of one half-bridge leg: a high-side gate and a low-side gate. Each gate has its own command input. The block acts on command edges and ignores levels. When a command rises, the gate on the opposite side is switched off on the same clock edge. The commanded gate is then held off until a programmable deadtime has run out. When a command falls, its gate switches off at once.

A small register port holds three things: the deadtime in clock ticks, a one-time mode that lets both gates conduct together with no deadtime, and a lock bit that freezes these settings. The paired mode can be changed only after a two-key unlock sequence, and only once per reset. At a 20 MHz clock, one tick is 50 ns. The 240-tick ceiling therefore gives a 12 µs maximum deadtime.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: After reset, both gates are off. The deadtime register reads DT_RESET (default 20). The mode register reads 0: paired mode off and unlocked.
- R2: A write to address 0 sets the deadtime. A value above DT_MAX (default 240) is stored as DT_MAX. Address 0 reads back the stored value.
- R3: In normal mode, a rising edge on one command turns the opposite gate off on the clock edge that samples the rise.
- R4: In normal mode, the commanded gate turns on D+1 clock edges after the rise is sampled, where D is the deadtime. With D=0 it turns on at the very next edge.
- R5: A command that stays high after its gate was switched off by the other side does not turn that gate on again. Only a new rising edge does.
- R6: A falling command turns its gate off on the edge that samples the fall, and cancels any turn-on still pending for that gate.
- R7: A rising edge while a turn-on is pending cancels that turn-on. The deadtime then restarts for the newly commanded side.
- R8: In normal mode, if both commands rise on the same edge, both gates turn off and no turn-on is left pending.
- R9: Paired mode is taken from bit 0 of a write to address 2 only when that write directly follows writes of 0xA5 and then 0x5A to address 1. Any other write between these steps aborts the sequence. Without the sequence, bit 0 is ignored.
- R10: Paired mode can be changed through the sequence only once per reset. Later sequences leave it unchanged.
- R11: In paired mode, each gate turns on at its own command's rising edge and off at its falling edge, with no deadtime. Both gates may be on together.
- R12: A write to address 2 with bit 1 set locks the settings. After that, writes to addresses 0 and 2 change nothing. The mode register reads {locked, paired} in bits 1:0.
- R13: Address 1 reads 0. Address 3 reads {pending, lowGate, highGate} in bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz clock; one tick is one deadtime step |
| rstN | input | 1 | Active-low synchronous reset |
| hiCmd | input | 1 | High-side command (edge sensitive) |
| loCmd | input | 1 | Low-side command (edge sensitive) |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address for write and read |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for regAddr |
| hiGate | output | 1 | High-side gate enable |
| loGate | output | 1 | Low-side gate enable |

## Verification
The bench builds the block with its default parameters: an 8-bit deadtime, a ceiling of 240 and a reset value of 20. With these, a write of 250 exercises saturation. Deadtimes of 3 and 0 keep the exact turn-on edge, the restart and the cancel windows only a few cycles long. Each gate transition is checked on the one edge where it must occur and on the edge just before it. This covers the unlock sequence with and without an abort, the once-only rule and the lock.

// File: rtl/hb_dt_pkg.sv
package hb_dt_pkg;
  localparam int HbDtW = 8;

  localparam logic [1:0] RegDeadtime = 2'd0;
  localparam logic [1:0] RegKey      = 2'd1;
  localparam logic [1:0] RegMode     = 2'd2;
  localparam logic [1:0] RegStatus   = 2'd3;

  localparam logic [HbDtW-1:0] KeyFirst  = 8'hA5;
  localparam logic [HbDtW-1:0] KeySecond = 8'h5A;

  // settings handed from the register side to the gate datapath
  typedef struct packed {
    logic             simOn;
    logic [HbDtW-1:0] deadtime;
  } hbCtrlT;

  typedef enum logic [1:0] {KeyIdle, KeyHalf, KeyArmed} keyStateT;
endpackage

// File: rtl/hb_dt_regs.sv
module hb_dt_regs
  import hb_dt_pkg::*;
#(
  parameter int DT_MAX   = 240,
  parameter int DT_RESET = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       addr,
  input  logic [HbDtW-1:0] wrData,
  input  logic [2:0]       status,
  output logic [HbDtW-1:0] rdData,
  output hbCtrlT           ctrl
);
  localparam logic [HbDtW-1:0] DtCap  = HbDtW'(DT_MAX);
  localparam logic [HbDtW-1:0] DtInit = HbDtW'(DT_RESET);

  logic [HbDtW-1:0] dtReg;
  logic             simOn;
  logic             modeUsed;
  logic             locked;
  keyStateT         keyState;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dtReg    <= DtInit;
      simOn    <= 1'b0;
      modeUsed <= 1'b0;
      locked   <= 1'b0;
      keyState <= KeyIdle;
    end else if (wrEn) begin
      keyState <= KeyIdle;
      unique case (addr)
        RegDeadtime: begin
          if (!locked) dtReg <= (wrData > DtCap) ? DtCap : wrData;
        end
        RegKey: begin
          if (wrData == KeyFirst)
            keyState <= KeyHalf;
          else if (keyState == KeyHalf && wrData == KeySecond)
            keyState <= KeyArmed;
        end
        RegMode: begin
          if (keyState == KeyArmed && !modeUsed && !locked) begin
            simOn    <= wrData[0];
            modeUsed <= 1'b1;
          end
          if (wrData[1]) locked <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr)
      RegDeadtime: rdData = dtReg;
      RegMode:     rdData = {{(HbDtW-2){1'b0}}, locked, simOn};
      RegStatus:   rdData = {{(HbDtW-3){1'b0}}, status};
      default:     rdData = '0;
    endcase
  end

  assign ctrl.simOn    = simOn;
  assign ctrl.deadtime = dtReg;

  assert_dt_cap_R2: assert property (@(posedge clk) disable iff (!rstN)
    dtReg <= DtCap);
  assert_lock_freeze_R12: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> ($stable(dtReg) && $stable(simOn)));
  assert_mode_once_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(simOn) |-> $rose(modeUsed));
endmodule

// File: rtl/hb_dt_bridge.sv
module hb_dt_bridge
  import hb_dt_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  hbCtrlT ctrl,
  input  logic   hiCmd,
  input  logic   loCmd,
  output logic   hiGate,
  output logic   loGate,
  output logic   pending
);
  logic             hiPrev, loPrev;
  logic             pendHi, pendLo;
  logic [HbDtW-1:0] cnt;

  logic hiRise, hiFall, loRise, loFall;
  assign hiRise = hiCmd & ~hiPrev;
  assign hiFall = ~hiCmd & hiPrev;
  assign loRise = loCmd & ~loPrev;
  assign loFall = ~loCmd & loPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiPrev <= 1'b0;
      loPrev <= 1'b0;
      hiGate <= 1'b0;
      loGate <= 1'b0;
      pendHi <= 1'b0;
      pendLo <= 1'b0;
      cnt    <= '0;
    end else begin
      hiPrev <= hiCmd;
      loPrev <= loCmd;
      if (ctrl.simOn) begin
        pendHi <= 1'b0;
        pendLo <= 1'b0;
        cnt    <= '0;
        if (hiRise) hiGate <= 1'b1;
        if (hiFall) hiGate <= 1'b0;
        if (loRise) loGate <= 1'b1;
        if (loFall) loGate <= 1'b0;
      end else if (hiRise && loRise) begin
        hiGate <= 1'b0;
        loGate <= 1'b0;
        pendHi <= 1'b0;
        pendLo <= 1'b0;
      end else if (hiRise) begin
        loGate <= 1'b0;
        hiGate <= 1'b0;
        pendHi <= 1'b1;
        pendLo <= 1'b0;
        cnt    <= ctrl.deadtime;
      end else if (loRise) begin
        hiGate <= 1'b0;
        loGate <= 1'b0;
        pendLo <= 1'b1;
        pendHi <= 1'b0;
        cnt    <= ctrl.deadtime;
      end else begin
        if (pendHi || pendLo) begin
          if (cnt == '0) begin
            hiGate <= pendHi;
            loGate <= pendLo;
            pendHi <= 1'b0;
            pendLo <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        if (hiFall) begin
          hiGate <= 1'b0;
          pendHi <= 1'b0;
        end
        if (loFall) begin
          loGate <= 1'b0;
          pendLo <= 1'b0;
        end
      end
    end
  end

  assign pending = pendHi | pendLo;

  assert_hi_kills_lo_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.simOn && hiRise) |=> !loGate);
  assert_lo_kills_hi_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.simOn && loRise) |=> !hiGate);
  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.simOn |-> !(hiGate && loGate));
  assert_hi_after_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.simOn && $rose(hiGate)) |-> !$past(loGate));
  assert_lo_after_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.simOn && $rose(loGate)) |-> !$past(hiGate));
endmodule

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl
  import hb_dt_pkg::*;
#(
  parameter int DT_MAX   = 240,
  parameter int DT_RESET = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hiCmd,
  input  logic       loCmd,
  input  logic       regWrEn,
  input  logic [1:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       hiGate,
  output logic       loGate
);
  hbCtrlT ctrl;
  logic   pending;

  hb_dt_regs #(.DT_MAX(DT_MAX), .DT_RESET(DT_RESET)) uRegs (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (regWrEn),
    .addr   (regAddr),
    .wrData (regWrData),
    .status ({pending, loGate, hiGate}),
    .rdData (regRdData),
    .ctrl   (ctrl)
  );

  hb_dt_bridge uBridge (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .hiCmd   (hiCmd),
    .loCmd   (loCmd),
    .hiGate  (hiGate),
    .loGate  (loGate),
    .pending (pending)
  );
endmodule

// File: tb/tb_hb_deadtime_ctrl.sv
module tb_hb_deadtime_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hiCmd = 1'b0;
  logic       loCmd = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       hiGate, loGate;

  hb_deadtime_ctrl dut (
    .clk(clk), .rstN(rstN), .hiCmd(hiCmd), .loCmd(loCmd),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .hiGate(hiGate), .loGate(loGate)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  // scoreboard: expected gate pair per absolute cycle
  int         expCyc[$];
  logic [1:0] expVal[$];
  string      expTag[$];

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic expectAt(int at, logic hi, logic lo, string tag);
    expCyc.push_back(at);
    expVal.push_back({hi, lo});
    expTag.push_back(tag);
  endtask

  always @(negedge clk) begin
    while (expCyc.size() > 0 && expCyc[0] <= cyc) begin
      if (expCyc[0] < cyc)
        check(1'b0, {expTag[0], " missed"}, {hiGate, loGate}, expVal[0]);
      else
        check({hiGate, loGate} == expVal[0], expTag[0], {hiGate, loGate}, expVal[0]);
      void'(expCyc.pop_front());
      void'(expVal.pop_front());
      void'(expTag.pop_front());
    end
  end

  task automatic drain();
    while (expCyc.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic setCmd(logic hi, logic lo, output int base);
    @(negedge clk);
    hiCmd = hi;
    loCmd = lo;
    base = cyc;
  endtask

  task automatic regWrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1;
    regAddr = a;
    regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readCheck(logic [1:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    check(regRdData == exp, tag, regRdData, exp);
  endtask

  initial begin
    int b, b2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check({hiGate, loGate} == 2'b00, "R1 gates", {hiGate, loGate}, 0);
    readCheck(2'd0, 8'd20, "R1 deadtime");
    readCheck(2'd2, 8'd0, "R1 mode");
    // R2 saturation
    regWrite(2'd0, 8'd250);
    readCheck(2'd0, 8'd240, "R2 saturate");
    regWrite(2'd0, 8'd3);
    readCheck(2'd0, 8'd3, "R2 write");
    // R3/R4 high side with D=3
    setCmd(1, 0, b);
    expectAt(b + 1, 0, 0, "R3 hi rise");
    expectAt(b + 4, 0, 0, "R4 hi early");
    expectAt(b + 5, 1, 0, "R4 hi on");
    drain();
    readCheck(2'd3, 8'h01, "R13 status");
    readCheck(2'd1, 8'h00, "R13 key reads 0");
    // low rises while high held: high off at once, low after deadtime
    setCmd(1, 1, b);
    expectAt(b + 1, 0, 0, "R3 lo rise kills hi");
    expectAt(b + 4, 0, 0, "R4 lo early");
    expectAt(b + 5, 0, 1, "R4 lo on");
    drain();
    // R6 falling low, R5 held high does not reassert
    setCmd(1, 0, b);
    expectAt(b + 1, 0, 0, "R6 lo fall");
    expectAt(b + 3, 0, 0, "R5 held hi stays off");
    drain();
    setCmd(0, 0, b);
    drain();
    // R7 restart on new edge during pending
    setCmd(1, 0, b);
    setCmd(1, 1, b2);
    expectAt(b + 5, 0, 0, "R7 hi cancelled");
    expectAt(b2 + 4, 0, 0, "R7 lo early");
    expectAt(b2 + 5, 0, 1, "R7 lo on");
    drain();
    setCmd(0, 0, b);
    expectAt(b + 1, 0, 0, "R6 lo off");
    drain();
    // R8 simultaneous rise
    setCmd(1, 1, b);
    expectAt(b + 1, 0, 0, "R8 both off");
    expectAt(b + 6, 0, 0, "R8 none on");
    drain();
    readCheck(2'd3, 8'h00, "R8 nothing pending");
    setCmd(0, 0, b);
    drain();
    // R4 zero deadtime
    regWrite(2'd0, 8'd0);
    setCmd(1, 0, b);
    expectAt(b + 1, 0, 0, "R4 D0 first edge");
    expectAt(b + 2, 1, 0, "R4 D0 on");
    drain();
    setCmd(0, 0, b);
    expectAt(b + 1, 0, 0, "R6 hi fall");
    drain();
    // R6 fall cancels pending
    regWrite(2'd0, 8'd3);
    setCmd(1, 0, b);
    setCmd(0, 0, b2);
    expectAt(b + 5, 0, 0, "R6 cancel");
    expectAt(b + 6, 0, 0, "R6 cancel later");
    drain();
    // R9 mode write without sequence ignored
    regWrite(2'd2, 8'h01);
    readCheck(2'd2, 8'h00, "R9 no sequence");
    // R9 aborted sequence
    regWrite(2'd1, 8'hA5);
    regWrite(2'd0, 8'd3);
    regWrite(2'd1, 8'h5A);
    regWrite(2'd2, 8'h01);
    readCheck(2'd2, 8'h00, "R9 aborted");
    // R9 proper sequence
    regWrite(2'd1, 8'hA5);
    regWrite(2'd1, 8'h5A);
    regWrite(2'd2, 8'h01);
    readCheck(2'd2, 8'h01, "R9 enabled");
    // R11 paired mode
    setCmd(1, 1, b);
    expectAt(b + 1, 1, 1, "R11 both on");
    drain();
    setCmd(0, 1, b);
    expectAt(b + 1, 0, 1, "R11 hi off only");
    drain();
    setCmd(0, 0, b);
    expectAt(b + 1, 0, 0, "R11 lo off");
    drain();
    // R10 second sequence ignored
    regWrite(2'd1, 8'hA5);
    regWrite(2'd1, 8'h5A);
    regWrite(2'd2, 8'h00);
    readCheck(2'd2, 8'h01, "R10 once only");
    // R12 lock
    regWrite(2'd2, 8'h02);
    readCheck(2'd2, 8'h03, "R12 locked");
    regWrite(2'd0, 8'd9);
    readCheck(2'd0, 8'd3, "R12 deadtime frozen");
    // R1 reset mid-run
    setCmd(1, 0, b);
    drain();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check({hiGate, loGate} == 2'b00, "R1 reset gates", {hiGate, loGate}, 0);
    hiCmd = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    readCheck(2'd0, 8'd20, "R1 deadtime after reset");
    readCheck(2'd2, 8'd0, "R1 mode after reset");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule